// File: doc/BRIEF.md
# DRAM Strobe Command Decoder

This block sits on the device side of a small behavioural DRAM model. It samples the active-low row strobe, column strobe, write enable and output enable on a fast system clock. It works out from the order of their edges which kind of memory cycle the controller is running: read, early write, read-modify-write, row-only refresh, refresh with column strobe first, or test-mode entry. It latches the row and column addresses for the storage array, keeps the internal refresh row counter and holds the test-mode flag from one cycle to the next.

The array gives the decoder the two data words that differ only in the top column address bit. The decoder drives the output data lanes and their enable. In normal mode it passes the word picked by the top column bit. In test mode it returns a per-lane equality result of the two words. When the row strobe rises and a memory cycle ends, the decoder gives a one-clock pulse that carries an encoded command type.

The command pulse is a plain status strobe and has no ready signal. The memory cycles are paced by the external controller's strobes, so the decoder cannot hold them back. A consumer must take the pulse in the clock cycle it appears.

Top module: `dram_strobe_decoder`

## Requirements
- R1: After reset, cmd_valid, dq_oe and test_mode are 0, row_addr and col_addr are 0, and the first refresh that uses the internal counter reports row 0.
- R2: A row strobe fall that is sampled while the column strobe is high latches all 11 address bits into row_addr. Each sampled column strobe fall in the open row latches address bits 9..0 into col_addr.
- R3: In the clock after the row strobe is first sampled high again, cmd_valid is 1 for exactly one cycle, and cmd_type shows the cycle kind: 1 read, 2 early write, 3 read-modify-write, 4 row-only refresh, 5 counter refresh, 6 test entry.
- R4: If write enable is high when the column strobe fall is sampled, the cycle is a read (type 1). dq_oe is 1 in each clock after a sample with row strobe, column strobe and output enable all low, and 0 otherwise. dq_out carries arr_rdata[7:0] when col_addr[9] is 0 and arr_rdata[15:8] when it is 1.
- R5: If write enable is low when the column strobe fall is sampled, the cycle is an early write (type 2), and dq_oe stays 0 even with output enable low.
- R6: If write enable is sampled low while the column strobe is low in a read, the cycle becomes read-modify-write (type 3), and dq_oe drops to 0 in the next clock.
- R7: A row cycle with no column strobe fall is a row-only refresh (type 4). It clears test_mode at the row strobe rise.
- R8: If the column strobe is low and write enable is high at the sampled row strobe fall, the cycle is a counter refresh (type 5). row_addr shows the 11-bit refresh counter and the external address is ignored. test_mode clears in the clock after the fall. dq_oe stays 0.
- R9: If the column strobe and write enable are both low at the sampled row strobe fall, the cycle is test entry (type 6). test_mode is 1 from the next clock and stays set through reads and writes. The cycle also reports the counter row.
- R10: When test_mode is 1, dq_out bit i of a read is 1 when arr_rdata[i] equals arr_rdata[i+8] and 0 otherwise, whatever col_addr[9] is.
- R11: The refresh counter advances by one after each type 5 or type 6 cycle and wraps from 2047 to 0.
- R12: If the column strobe is held low across a row strobe rise and a new fall, the second row cycle is a counter refresh (hidden refresh).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | 11 | Multiplexed address |
| arr_rdata | input | 16 | Array words: [7:0] at column bit 9 = 0, [15:8] at column bit 9 = 1 |
| cmd_valid | output | 1 | One-clock pulse when a memory cycle ends |
| cmd_type | output | 3 | Kind of the cycle that ended |
| row_addr | output | 11 | Latched row (or refresh counter) |
| col_addr | output | 10 | Latched column |
| dq_oe | output | 1 | Data output enable |
| dq_out | output | 8 | Output data, 0 when disabled |
| test_mode | output | 1 | Latched test-mode flag |

## Verification
On every cycle the assertions check that the command pulse lasts one clock and follows a row strobe rise. They check that the output enable is only set after the row strobe, column strobe and output enable were all sampled low, and that no write or refresh cycle had the output driven. They also check that test entry leaves the flag set and that either kind of refresh leaves it clear. Only the bench scenarios can show which address gets latched, which data word is selected, the value of the equality compare, the exact counter sequence through its wrap, and the hidden-refresh case.

// File: rtl/dsd_pkg.sv
package dsd_pkg;
  typedef enum logic [2:0] {
    CMD_NONE   = 3'd0,
    CMD_READ   = 3'd1,
    CMD_EWRITE = 3'd2,
    CMD_RMW    = 3'd3,
    CMD_RONLY  = 3'd4,
    CMD_CBR    = 3'd5,
    CMD_TEST   = 3'd6
  } cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_OPEN = 2'd1,
    ST_RFSH = 2'd2
  } phase_e;
endpackage

// File: rtl/dsd_strobe_history.sv
module dsd_strobe_history #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] prev
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n) prev[i] <= 1'b1;
      else        prev[i] <= lvl[i];
    end
  end
endmodule

// File: rtl/dsd_refresh_ctr.sv
module dsd_refresh_ctr #(
  parameter int ROW_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  output logic [ROW_W-1:0] count
);
  localparam logic [ROW_W-1:0] ONE = ROW_W'(1);
  always_ff @(posedge clk) begin
    if (!rst_n)   count <= '0;
    else if (inc) count <= count + ONE;
  end
endmodule

// File: rtl/dsd_cycle_fsm.sv
module dsd_cycle_fsm
  import dsd_pkg::*;
#(
  parameter int ROW_W = 11,
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ras_n,
  input  logic             cas_n,
  input  logic             we_n,
  input  logic             oe_n,
  input  logic             ras_prev,
  input  logic             cas_prev,
  input  logic [ROW_W-1:0] addr,
  input  logic [ROW_W-1:0] ctr,
  output logic             ctr_inc,
  output logic             cmd_valid,
  output cmd_e             cmd_type,
  output logic [ROW_W-1:0] row_addr,
  output logic [COL_W-1:0] col_addr,
  output logic             dq_oe,
  output logic             test_mode
);
  phase_e           st_q, st_d;
  cmd_e             kind_q, kind_d, type_d;
  logic [ROW_W-1:0] row_d;
  logic [COL_W-1:0] col_d;
  logic             test_d, vld_d, oe_d;
  logic             ras_fall, ras_rise, cas_fall;

  assign ras_fall = ras_prev & ~ras_n;
  assign ras_rise = ~ras_prev & ras_n;
  assign cas_fall = cas_prev & ~cas_n;

  always_comb begin
    st_d    = st_q;
    kind_d  = kind_q;
    row_d   = row_addr;
    col_d   = col_addr;
    test_d  = test_mode;
    type_d  = cmd_type;
    vld_d   = 1'b0;
    ctr_inc = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (ras_fall) begin
          if (!cas_n) begin
            row_d = ctr;
            st_d  = ST_RFSH;
            if (!we_n) begin
              kind_d = CMD_TEST;
              test_d = 1'b1;
            end else begin
              kind_d = CMD_CBR;
              test_d = 1'b0;
            end
          end else begin
            row_d  = addr;
            kind_d = CMD_RONLY;
            st_d   = ST_OPEN;
          end
        end
      end
      ST_OPEN: begin
        if (ras_rise) begin
          vld_d  = 1'b1;
          type_d = kind_q;
          st_d   = ST_IDLE;
          if (kind_q == CMD_RONLY) test_d = 1'b0;
        end else if (cas_fall) begin
          col_d  = addr[COL_W-1:0];
          kind_d = we_n ? CMD_READ : CMD_EWRITE;
        end else if (kind_q == CMD_READ && !cas_n && !we_n) begin
          kind_d = CMD_RMW;
        end
      end
      ST_RFSH: begin
        if (ras_rise) begin
          vld_d   = 1'b1;
          type_d  = kind_q;
          st_d    = ST_IDLE;
          ctr_inc = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
    oe_d = (st_d == ST_OPEN) && (kind_d == CMD_READ) && !cas_n && !oe_n;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      kind_q    <= CMD_NONE;
      row_addr  <= '0;
      col_addr  <= '0;
      test_mode <= 1'b0;
      cmd_valid <= 1'b0;
      cmd_type  <= CMD_NONE;
      dq_oe     <= 1'b0;
    end else begin
      st_q      <= st_d;
      kind_q    <= kind_d;
      row_addr  <= row_d;
      col_addr  <= col_d;
      test_mode <= test_d;
      cmd_valid <= vld_d;
      cmd_type  <= type_d;
      dq_oe     <= oe_d;
    end
  end
endmodule

// File: rtl/dsd_dq_path.sv
module dsd_dq_path #(
  parameter int DQ_W = 8
) (
  input  logic [2*DQ_W-1:0] arr_rdata,
  input  logic              col_msb,
  input  logic              test_mode,
  input  logic              dq_oe,
  output logic [DQ_W-1:0]   dq_out
);
  logic [DQ_W-1:0] lo_w, hi_w, same;
  assign lo_w = arr_rdata[DQ_W-1:0];
  assign hi_w = arr_rdata[2*DQ_W-1:DQ_W];

  for (genvar i = 0; i < DQ_W; i++) begin : g_lane
    assign same[i]   = ~(lo_w[i] ^ hi_w[i]);
    assign dq_out[i] = dq_oe & (test_mode ? same[i] : (col_msb ? hi_w[i] : lo_w[i]));
  end
endmodule

// File: rtl/dram_strobe_decoder.sv
module dram_strobe_decoder
  import dsd_pkg::*;
#(
  parameter int ROW_W = 11,
  parameter int COL_W = 10,
  parameter int DQ_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ROW_W-1:0]  addr,
  input  logic [2*DQ_W-1:0] arr_rdata,
  output logic              cmd_valid,
  output logic [2:0]        cmd_type,
  output logic [ROW_W-1:0]  row_addr,
  output logic [COL_W-1:0]  col_addr,
  output logic              dq_oe,
  output logic [DQ_W-1:0]   dq_out,
  output logic              test_mode
);
  localparam int NSTROBE = 2;

  logic [NSTROBE-1:0] prev;
  logic [ROW_W-1:0]   ctr;
  logic               ctr_inc;
  cmd_e               type_e;

  dsd_strobe_history #(.N(NSTROBE)) u_hist (
    .clk(clk), .rst_n(rst_n), .lvl({cas_n, ras_n}), .prev(prev)
  );

  dsd_refresh_ctr #(.ROW_W(ROW_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .inc(ctr_inc), .count(ctr)
  );

  dsd_cycle_fsm #(.ROW_W(ROW_W), .COL_W(COL_W)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .oe_n(oe_n),
    .ras_prev(prev[0]), .cas_prev(prev[1]),
    .addr(addr), .ctr(ctr), .ctr_inc(ctr_inc),
    .cmd_valid(cmd_valid), .cmd_type(type_e),
    .row_addr(row_addr), .col_addr(col_addr),
    .dq_oe(dq_oe), .test_mode(test_mode)
  );

  assign cmd_type = type_e;

  dsd_dq_path #(.DQ_W(DQ_W)) u_dq (
    .arr_rdata(arr_rdata), .col_msb(col_addr[COL_W-1]),
    .test_mode(test_mode), .dq_oe(dq_oe), .dq_out(dq_out)
  );
endmodule

// File: rtl/dsd_checker.sv
module dsd_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       ras_n,
  input logic       cas_n,
  input logic       oe_n,
  input logic       cmd_valid,
  input logic [2:0] cmd_type,
  input logic       dq_oe,
  input logic       test_mode
);
  a_r3_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);

  a_r3_pulse_after_rise: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> ($past(ras_n) && !$past(ras_n, 2)));

  a_r4_oe_needs_strobes: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> (!$past(ras_n) && !$past(cas_n) && !$past(oe_n)));

  a_r5_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_type == 3'd2) |-> !$past(dq_oe));

  a_r8_refresh_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && (cmd_type == 3'd4 || cmd_type == 3'd5 || cmd_type == 3'd6)) |-> !$past(dq_oe));

  a_r9_test_latched: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_type == 3'd6) |-> test_mode);

  a_r7_ronly_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_type == 3'd4) |-> !test_mode);

  a_r8_cbr_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_type == 3'd5) |-> !test_mode);
endmodule

bind dram_strobe_decoder dsd_checker u_chk (
  .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .oe_n(oe_n),
  .cmd_valid(cmd_valid), .cmd_type(cmd_type), .dq_oe(dq_oe), .test_mode(test_mode)
);

// File: tb/sim_dram_strobe_decoder.sv
`timescale 1ns/1ps
module sim_dram_strobe_decoder;
  localparam int ROW_W = 11;
  localparam int COL_W = 10;
  localparam int DQ_W  = 8;
  localparam int NROWS = 1 << ROW_W;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [ROW_W-1:0]  addr = '0;
  logic [2*DQ_W-1:0] arr_rdata = '0;
  logic              cmd_valid, dq_oe, test_mode;
  logic [2:0]        cmd_type;
  logic [ROW_W-1:0]  row_addr;
  logic [COL_W-1:0]  col_addr;
  logic [DQ_W-1:0]   dq_out;

  int checks = 0;
  int errors = 0;
  int exp_ctr = 0;
  bit exp_tm = 1'b0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dram_strobe_decoder #(.ROW_W(ROW_W), .COL_W(COL_W), .DQ_W(DQ_W)) u0 (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .arr_rdata(arr_rdata), .cmd_valid(cmd_valid), .cmd_type(cmd_type),
    .row_addr(row_addr), .col_addr(col_addr), .dq_oe(dq_oe), .dq_out(dq_out),
    .test_mode(test_mode)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  function automatic logic [DQ_W-1:0] exp_dq(bit tm, bit msb, logic [2*DQ_W-1:0] d);
    if (tm) return ~(d[DQ_W-1:0] ^ d[2*DQ_W-1:DQ_W]);
    return msb ? d[2*DQ_W-1:DQ_W] : d[DQ_W-1:0];
  endfunction

  task automatic finish_cycle(input int typ, input string req);
    ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    tick();
    chk(cmd_valid == 1'b1, "R3 pulse", cmd_valid, 1);
    chk(cmd_type == 3'(typ), req, cmd_type, typ);
    tick();
    chk(cmd_valid == 1'b0, "R3 single", cmd_valid, 0);
  endtask

  task automatic open_row(input int row);
    ras_n = 1'b0; addr = ROW_W'(row);
    tick();
    chk(row_addr == ROW_W'(row), "R2 row", row_addr, row);
  endtask

  task automatic do_read(input int row, input int col, input logic [2*DQ_W-1:0] d, input bit rmw);
    open_row(row);
    addr = ROW_W'(col); cas_n = 1'b0; oe_n = 1'b0; arr_rdata = d;
    tick();
    chk(col_addr == COL_W'(col), "R2 col", col_addr, col);
    chk(dq_oe == 1'b1, "R4 oe", dq_oe, 1);
    chk(dq_out == exp_dq(exp_tm, col[COL_W-1], d), exp_tm ? "R10 compare" : "R4 data",
        dq_out, exp_dq(exp_tm, col[COL_W-1], d));
    if (rmw) begin
      we_n = 1'b0;
      tick();
      chk(dq_oe == 1'b0, "R6 oe off", dq_oe, 0);
      finish_cycle(3, "R6 type");
    end else begin
      oe_n = 1'b1;
      tick();
      chk(dq_oe == 1'b0, "R4 oe follows", dq_oe, 0);
      finish_cycle(1, "R4 type");
    end
  endtask

  task automatic do_ewrite(input int row, input int col);
    open_row(row);
    addr = ROW_W'(col); cas_n = 1'b0; we_n = 1'b0; oe_n = 1'b0;
    tick();
    chk(dq_oe == 1'b0, "R5 oe", dq_oe, 0);
    tick();
    chk(dq_oe == 1'b0, "R5 oe hold", dq_oe, 0);
    finish_cycle(2, "R5 type");
    chk(test_mode == exp_tm, "R9 kept", test_mode, exp_tm);
  endtask

  task automatic do_ronly(input int row);
    open_row(row);
    tick();
    finish_cycle(4, "R7 type");
    exp_tm = 1'b0;
    chk(test_mode == 1'b0, "R7 clear", test_mode, 0);
  endtask

  task automatic do_cbr(input bit we);
    cas_n = 1'b0;
    tick();
    ras_n = 1'b0; we_n = we; oe_n = 1'b0; addr = ROW_W'((exp_ctr * 13 + 5) % NROWS) ^ 11'h555;
    tick();
    chk(row_addr == ROW_W'(exp_ctr), "R11 counter row", row_addr, exp_ctr);
    exp_tm = !we;
    chk(test_mode == exp_tm, we ? "R8 clear" : "R9 set", test_mode, exp_tm);
    chk(dq_oe == 1'b0, "R8 oe", dq_oe, 0);
    finish_cycle(we ? 5 : 6, we ? "R8 type" : "R9 type");
    exp_ctr = (exp_ctr + 1) % NROWS;
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R1 reset state
    chk(cmd_valid == 1'b0, "R1 valid", cmd_valid, 0);
    chk(dq_oe == 1'b0, "R1 oe", dq_oe, 0);
    chk(test_mode == 1'b0, "R1 test", test_mode, 0);
    chk(row_addr == '0 && col_addr == '0, "R1 addr", {row_addr, col_addr}, 0);

    for (int i = 0; i < 32; i++)
      do_read((i * 67) % NROWS, (i * 37 + i * 512) % 1024, 16'(i * 16'h1357 + 16'h0a5c), 1'b0);
    for (int i = 0; i < 8; i++) do_read(i * 200, i * 130, 16'(i * 16'h2f11), 1'b1);
    for (int i = 0; i < 8; i++) do_ewrite(i * 250, i * 99);
    do_ronly(17);

    do_cbr(1'b1);
    do_cbr(1'b0);
    do_read(3, 10, 16'h3c3c, 1'b0);
    do_read(4, 600, 16'h3cc3, 1'b0);
    for (int i = 0; i < 8; i++) do_read(i, i * 140, {8'(i * 29), 8'(i * 29) ^ 8'(1 << i)}, 1'b0);
    do_ewrite(5, 5);
    do_ronly(9);
    do_cbr(1'b0);
    do_cbr(1'b1);

    // R12 hidden refresh: column strobe held low across rise
    open_row(77);
    addr = 11'd300; cas_n = 1'b0; oe_n = 1'b0; arr_rdata = 16'hbeef;
    tick();
    ras_n = 1'b1;
    tick();
    chk(cmd_valid == 1'b1 && cmd_type == 3'd1, "R12 read end", cmd_type, 1);
    ras_n = 1'b0; oe_n = 1'b1;
    tick();
    chk(row_addr == ROW_W'(exp_ctr), "R12 counter row", row_addr, exp_ctr);
    finish_cycle(5, "R12 type");
    exp_ctr = (exp_ctr + 1) % NROWS;

    // R11 full sweep through the wrap
    for (int i = 0; i < NROWS + 4; i++) do_cbr(1'b1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule